// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with HI/LO Result Registers

This unit computes integer products and quotients for a processor core. It takes two 32-bit operands and produces a 64-bit split result in two architectural registers, HI and LO. A command is issued by raising `start` with an opcode while the unit is idle. Multiply and divide commands run iteratively, one bit per cycle, and hold `busy` high until the result is written. Two move commands load HI or LO directly from operand `a` in a single cycle. Either register can be read through a request port, and the port stalls a read while an operation is in flight.

Both arithmetic paths run on operand magnitudes and share one pair of 32-bit shift registers. A final sign correction is applied in the commit cycle. Division by zero finishes on the normal schedule with a fixed result, so the core never waits on it indefinitely.

Top module: `muldiv_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `hi` and `lo` read zero and `busy` is low.
- R2: The opcode on `op` is taken only when `start` is high and `busy` is low. The codes are 0 signed multiply, 1 unsigned multiply, 2 signed divide, 3 unsigned divide, 4 load HI, 5 load LO. Codes 6 and 7 change nothing. An arithmetic code raises `busy` after the accepting edge and keeps it high for exactly 32 cycles. The new `hi`/`lo` appear in the same cycle that `busy` falls.
- R3: Signed multiply writes bits 31:0 of the two's-complement 64-bit product to LO and bits 63:32 to HI.
- R4: Unsigned multiply does the same with both operands treated as unsigned.
- R5: Signed divide writes the quotient, truncated toward zero, to LO. It writes the remainder, which carries the dividend's sign, to HI.
- R6: Unsigned divide writes the unsigned quotient to LO and the remainder to HI.
- R7: A divide with `b` = 0 completes on the normal schedule with LO = 0xFFFFFFFF and HI equal to the dividend `a`. This holds for both signed and unsigned divide.
- R8: Signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R9: Codes 4 and 5 copy `a` into HI or LO on the accepting edge. They do not raise `busy`.
- R10: `rd_sel` chooses the register to read: 0 for LO, 1 for HI. When `rd_req` is high and the unit is idle, `rd_valid` is high and `rd_data` holds the selected register. While `busy` is high, `rd_valid` stays low.
- R11: A `start` issued while `busy` is high is ignored. The running result and its timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command strobe |
| op | input | 3 | Command code |
| a | input | 32 | First operand (multiplicand, dividend or move source) |
| b | input | 32 | Second operand (multiplier or divisor) |
| rd_req | input | 1 | Read request |
| rd_sel | input | 1 | Read select: 0 LO, 1 HI |
| busy | output | 1 | Operation in progress |
| rd_valid | output | 1 | Read data is valid this cycle |
| rd_data | output | 32 | Selected register value |
| hi | output | 32 | HI register |
| lo | output | 32 | LO register |

## Verification
Two conflicts are exercised. The first is a read request that overlaps a running operation. `rd_req` is held high and `rd_sel` toggles through every wait, so the stall and its release in the commit cycle are judged against a reference that computes the results with 64-bit arithmetic. The second is a new `start` that overlaps a busy unit. A move-to-HI is issued in the middle of a divide, and the reference, which ignores it, must agree with the HI, LO and `busy` values seen at every clock.

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
module muldiv_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         rd_req,
  input  logic         rd_sel,
  output logic         busy,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic           busy_q, is_div, neg_q, neg_r, dz;
  logic [CW-1:0]  cnt;
  logic [W-1:0]   mag_b, acc_hi, acc_lo, hi_q, lo_q;

  wire go      = start & ~busy_q;
  wire arith   = go & ~op[2];
  wire sgn     = ~op[0];
  wire a_neg   = sgn & a[W-1];
  wire b_neg   = sgn & b[W-1];
  wire done    = busy_q && cnt == LAST;

  wire [W:0]   msum  = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, mag_b} : '0);
  wire [W:0]   trial = {acc_hi, acc_lo[W-1]} - {1'b0, mag_b};
  wire         ge    = ~trial[W];

  logic [W-1:0] nxt_hi, nxt_lo;
  always_comb begin
    if (is_div) begin
      nxt_hi = ge ? trial[W-1:0] : {acc_hi[W-2:0], acc_lo[W-1]};
      nxt_lo = {acc_lo[W-2:0], ge};
    end else begin
      {nxt_hi, nxt_lo} = {msum, acc_lo[W-1:1]};
    end
  end

  wire [2*W-1:0] prod  = neg_q ? -{nxt_hi, nxt_lo} : {nxt_hi, nxt_lo};
  wire [W-1:0]   quo   = dz ? '1 : (neg_q ? -nxt_lo : nxt_lo);
  wire [W-1:0]   rem   = neg_r ? -nxt_hi : nxt_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt    <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      acc_hi <= '0;
      acc_lo <= '0;
      mag_b  <= '0;
      is_div <= 1'b0;
      neg_q  <= 1'b0;
      neg_r  <= 1'b0;
      dz     <= 1'b0;
    end else if (busy_q) begin
      acc_hi <= nxt_hi;
      acc_lo <= nxt_lo;
      cnt    <= cnt + 1'b1;
      if (done) begin
        busy_q <= 1'b0;
        hi_q   <= is_div ? rem : prod[2*W-1:W];
        lo_q   <= is_div ? quo : prod[W-1:0];
      end
    end else if (arith) begin
      busy_q <= 1'b1;
      cnt    <= '0;
      acc_hi <= '0;
      acc_lo <= a_neg ? -a : a;
      mag_b  <= b_neg ? -b : b;
      is_div <= op[1];
      neg_q  <= a_neg ^ b_neg;
      neg_r  <= a_neg;
      dz     <= (b == '0);
    end else if (go && op == 3'd4) begin
      hi_q <= a;
    end else if (go && op == 3'd5) begin
      lo_q <= a;
    end
  end

  assign busy     = busy_q;
  assign hi       = hi_q;
  assign lo       = lo_q;
  assign rd_valid = rd_req & ~busy_q;
  assign rd_data  = rd_sel ? hi_q : lo_q;

  logic [CW:0] blen;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy_q) blen <= '0;
    else                   blen <= blen + 1'b1;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> blen == (CW+1)'(W)); // R2
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(hi) && $stable(lo)); // R11
  AST_MOVE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && op == 3'd4 |=> hi == $past(a) && !busy); // R9
  AST_MOVE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && op == 3'd5 |=> lo == $past(a) && !busy); // R9
  AST_ARITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !op[2] |=> busy); // R2
  AST_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && $rose(busy) |-> !rd_valid); // R10
endmodule

// File: tb/muldiv_unit_bench.sv
`timescale 1ns/1ps
module muldiv_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op = 3'd0;
  logic [31:0] a = '0, b = '0;
  logic rd_req = 1'b0, rd_sel = 1'b0;
  logic busy, rd_valid;
  logic [31:0] rd_data, hi, lo;

  always #2.5 clk = ~clk;

  muldiv_unit u_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
    .rd_req(rd_req), .rd_sel(rd_sel), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .hi(hi), .lo(lo)
  );

  int vectors = 0, errors = 0;
  bit finished = 1'b0;
  string cur = "R1";

  logic [31:0] m_hi = '0, m_lo = '0, p_hi = '0, p_lo = '0;
  int m_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = '0; m_lo = '0; m_cnt = 0;
    end else if (m_cnt > 0) begin
      if (m_cnt == 1) begin m_hi = p_hi; m_lo = p_lo; end
      m_cnt = m_cnt - 1;
    end else if (start) begin
      longint sa, sb, q, r;
      longint unsigned ua, ub, up;
      sa = longint'(signed'(a)); sb = longint'(signed'(b));
      ua = {32'd0, a}; ub = {32'd0, b};
      case (op)
        3'd0: begin q = sa * sb; {p_hi, p_lo} = q; m_cnt = 32; end
        3'd1: begin up = ua * ub; {p_hi, p_lo} = up; m_cnt = 32; end
        3'd2: begin
          if (b == 0) begin p_lo = '1; p_hi = a; end
          else begin q = sa / sb; r = sa % sb; p_lo = q[31:0]; p_hi = r[31:0]; end
          m_cnt = 32;
        end
        3'd3: begin
          if (b == 0) begin p_lo = '1; p_hi = a; end
          else begin up = ua / ub; p_lo = up[31:0]; up = ua % ub; p_hi = up[31:0]; end
          m_cnt = 32;
        end
        3'd4: m_hi = a;
        3'd5: m_lo = a;
        default: ;
      endcase
    end
  end

  always @(negedge clk) if (!finished) begin
    logic e_busy, e_valid;
    e_busy  = (m_cnt != 0);
    e_valid = rd_req && !e_busy;
    vectors++;
    if (busy !== e_busy) begin
      errors++; $display("FAIL %s busy act %0b exp %0b", cur, busy, e_busy);
    end
    if (hi !== m_hi) begin
      errors++; $display("FAIL %s hi act %h exp %h", cur, hi, m_hi);
    end
    if (lo !== m_lo) begin
      errors++; $display("FAIL %s lo act %h exp %h", cur, lo, m_lo);
    end
    if (rd_valid !== e_valid) begin
      errors++; $display("FAIL %s rd_valid (R10) act %0b exp %0b", cur, rd_valid, e_valid);
    end
    if (e_valid && rd_data !== (rd_sel ? m_hi : m_lo)) begin
      errors++; $display("FAIL %s rd_data (R10) act %h exp %h", cur, rd_data, rd_sel ? m_hi : m_lo);
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic issue(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y, input string t);
    cur = t; start = 1'b1; op = o; a = x; b = y;
    tick(1);
    start = 1'b0; rd_req = 1'b1;
    for (int i = 0; i < 34; i++) begin rd_sel = ~rd_sel; tick(1); end
    rd_req = 1'b0;
  endtask

  task automatic summary;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++; $display("FAIL watchdog act running exp done");
    summary();
  end

  initial begin
    cur = "R1";
    tick(4);
    rst_n = 1'b1;
    tick(2);
    issue(3'd4, 32'h1234_5678, 32'h0, "R9");
    issue(3'd5, 32'h9ABC_DEF0, 32'h0, "R9");
    rd_req = 1'b1; rd_sel = 1'b1; cur = "R10"; tick(2); rd_sel = 1'b0; tick(2); rd_req = 1'b0;
    issue(3'd0, -32'sd3, 32'd7, "R3");
    issue(3'd0, 32'h8000_0000, 32'h8000_0000, "R3");
    issue(3'd0, '1, '1, "R3");
    issue(3'd0, 32'd12345, -32'sd6789, "R3");
    issue(3'd1, '1, '1, "R4");
    issue(3'd1, 32'h8000_0000, 32'd2, "R4");
    issue(3'd2, -32'sd7, 32'd2, "R5");
    issue(3'd2, 32'd7, -32'sd2, "R5");
    issue(3'd2, -32'sd7, -32'sd2, "R5");
    issue(3'd2, 32'd100, 32'd7, "R5");
    issue(3'd3, '1, 32'd3, "R6");
    issue(3'd3, 32'd5, 32'd10, "R6");
    issue(3'd2, -32'sd5, 32'd0, "R7");
    issue(3'd3, 32'd1234, 32'd0, "R7");
    issue(3'd2, 32'h8000_0000, '1, "R8");
    issue(3'd6, 32'hFFFF_0000, 32'd9, "R2");
    issue(3'd7, 32'h0000_FFFF, 32'd9, "R2");
    cur = "R11"; start = 1'b1; op = 3'd3; a = 32'd1000; b = 32'd33; tick(1);
    start = 1'b0; tick(5);
    start = 1'b1; op = 3'd4; a = 32'hDEAD_BEEF; tick(1);
    op = 3'd0; a = 32'd3; b = 32'd3; tick(1);
    start = 1'b0; rd_req = 1'b1; tick(30); rd_req = 1'b0;
    tick(2);
    summary();
  end
endmodule